// File: doc/BRIEF.md
# Burst Period Timer with Two-Span Validation

This block measures the period of a short Doppler burst. The input is a squared, one-bit copy of the burst. The block takes it through a synchronizer and detects its rising edges. The first rising edge of a burst clears a free-running clock-tick counter. The block then records the elapsed tick count at the fifth and at the eighth later rising edge. The signal frequency is read from the length of these spans. It is not read by counting cycles inside a fixed gate.

A noisy burst gives two spans that imply different frequencies, so the block checks that they agree. It scales the eight-cycle span by 5 and the five-cycle span by 8, both with shifts and adds. It then compares the gap between the two products against a tolerance made by right-shifting the scaled eight-cycle span. A 2-bit select sets the tolerance to 1/64, 1/32, 1/16 or 1/8. No multiplier is involved.

A burst that agrees is reported as its eight-cycle count with a one-clock valid strobe. A burst that disagrees, stalls or overruns the counter gives a one-clock reject. After either outcome the block waits for the next burst.

Top module: `burst_period_timer`

## Requirements
- R1: While rst_n is low, and after it rises until the first report, result_valid and reject are 0 and result_cnt is 0.
- R2: sig_in passes through a two-flop synchronizer. Only its rising edges count. The rising edge that starts a burst clears the tick count and is not itself a completed signal cycle.
- R3: For an accepted burst, result_cnt equals the number of clock cycles from the starting rising edge to the eighth later rising edge, so a steady period of P clocks reports 8·P. result_cnt is stable while result_valid is high.
- R4: Let N5 and N8 be the tick counts at the fifth and eighth later edges. The burst is accepted when |8·N5 − 5·N8| ≤ (5·N8) >> k, computed 20 bits wide. tol_sel values 0, 1, 2 and 3 select k = 6, 5, 4 and 3.
- R5: A burst that fails the R4 rule gives reject and no result_valid.
- R6: If no rising edge arrives for more than timeout_lim clock cycles after the previous edge of a burst in progress, the burst is abandoned with reject.
- R7: If the tick count reaches 2^16−1 before the eighth edge, the burst is abandoned with reject.
- R8: Every report is a single-clock pulse on exactly one of result_valid or reject, and the two are never high together.
- R9: Edges that arrive while the result is being checked or reported are ignored. The next rising edge after the report starts a new burst, so a continuous signal yields back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; ticks are counted on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Squared burst signal, asynchronous to clk |
| tol_sel | input | 2 | Tolerance select: 0 → 1/64, 1 → 1/32, 2 → 1/16, 3 → 1/8 |
| timeout_lim | input | 16 | Largest allowed edge-to-edge gap in clock cycles |
| result_valid | output | 1 | One-clock strobe for an accepted burst |
| result_cnt | output | 16 | Eight-cycle tick count of the last completed burst |
| reject | output | 1 | One-clock strobe for a rejected or abandoned burst |

## Verification
The assertions assume that tol_sel and timeout_lim do not change during a burst. They also assume that every high and low phase of sig_in lasts at least one clock, so that no edge is lost in the synchronizer. The stimulus drives sig_in only on falling clock edges, with phases of at least two clocks. It changes tol_sel and timeout_lim only between bursts, after the previous result has been seen. Each burst is built from a list of edge-to-edge intervals. From that list the bench computes N5, N8 and the agreement rule directly. Its interval lists include steady periods, a burst that sits just across the 1/64 and 1/32 limits, a stall, and spans long enough to overrun the counter.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SPAN5  = 3'd1,
      ST_SPAN8  = 3'd2,
      ST_CHECK  = 3'd3,
      ST_REPORT = 3'd4
   } bpt_state_e;

   localparam int FIRST_MARK  = 5;
   localparam int SECOND_MARK = 8;

endpackage

// File: rtl/bpt_edge_sync.sv
module bpt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bpt_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/bpt_span_counter.sv
module bpt_span_counter #(
   parameter int CNT_W = 16,
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic             edge_i,
   input  logic [TMO_W-1:0] timeout_lim,
   output logic [CNT_W-1:0] span,
   output logic             saturated,
   output logic             timed_out
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [TMO_W-1:0] GAP_MAX = {TMO_W{1'b1}};

   if (CNT_W < 8) begin : g_bad_cnt
      $error("bpt_span_counter: CNT_W must be at least 8");
   end
   if (TMO_W < 2) begin : g_bad_tmo
      $error("bpt_span_counter: TMO_W must be at least 2");
   end

   logic [CNT_W-1:0] elapsed_q;
   logic [TMO_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
         gap_q     <= '0;
      end else if (clear) begin
         elapsed_q <= '0;
         gap_q     <= '0;
      end else if (run) begin
         if (elapsed_q != CNT_MAX) elapsed_q <= elapsed_q + CNT_W'(1);
         if (edge_i)               gap_q     <= '0;
         else if (gap_q != GAP_MAX) gap_q    <= gap_q + TMO_W'(1);
      end
   end

   assign saturated = (elapsed_q == CNT_MAX);
   assign span      = saturated ? CNT_MAX : elapsed_q + CNT_W'(1);
   assign timed_out = run & ~edge_i & (gap_q >= timeout_lim);
endmodule

// File: rtl/bpt_agree_check.sv
module bpt_agree_check #(
   parameter int CNT_W = 16,
   parameter int EXT_W = CNT_W + 4
) (
   input  logic [CNT_W-1:0] n5,
   input  logic [CNT_W-1:0] n8,
   input  logic [1:0]       tol_sel,
   output logic             pass
);
   if (EXT_W < CNT_W + 3) begin : g_bad_ext
      $error("bpt_agree_check: EXT_W too narrow for 5x and 8x products");
   end

   logic [EXT_W-1:0] scaled5;
   logic [EXT_W-1:0] scaled8;
   logic [EXT_W-1:0] gap;
   logic [EXT_W-1:0] allow;

   always_comb begin
      scaled5 = EXT_W'(n5) << 3;
      scaled8 = (EXT_W'(n8) << 2) + EXT_W'(n8);
      gap     = (scaled5 >= scaled8) ? scaled5 - scaled8 : scaled8 - scaled5;
      unique case (tol_sel)
         2'd0:    allow = scaled8 >> 6;
         2'd1:    allow = scaled8 >> 5;
         2'd2:    allow = scaled8 >> 4;
         default: allow = scaled8 >> 3;
      endcase
      pass = (gap <= allow);
   end
endmodule

// File: rtl/burst_period_timer.sv
module burst_period_timer #(
   parameter int CNT_W       = 16,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sig_in,
   input  logic [1:0]       tol_sel,
   input  logic [TMO_W-1:0] timeout_lim,
   output logic             result_valid,
   output logic [CNT_W-1:0] result_cnt,
   output logic             reject
);
   import bpt_pkg::*;

   localparam int MARK_W = $clog2(SECOND_MARK + 1);
   localparam logic [MARK_W-1:0] MARK5 = MARK_W'(FIRST_MARK);
   localparam logic [MARK_W-1:0] MARK8 = MARK_W'(SECOND_MARK);

   bpt_state_e       state;
   logic             rise;
   logic             clear;
   logic             run;
   logic [CNT_W-1:0] span;
   logic             saturated;
   logic             timed_out;
   logic             pass;
   logic [MARK_W-1:0] mark_q;
   logic [MARK_W-1:0] mark_nx;
   logic [CNT_W-1:0] n5_q;
   logic [CNT_W-1:0] n8_q;
   logic             ok_q;

   bpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sig_in),
      .rise (rise)
   );

   assign clear = (state == ST_IDLE) & rise;
   assign run   = (state == ST_SPAN5) | (state == ST_SPAN8);

   bpt_span_counter #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .run        (run),
      .edge_i     (rise),
      .timeout_lim(timeout_lim),
      .span       (span),
      .saturated  (saturated),
      .timed_out  (timed_out)
   );

   bpt_agree_check #(.CNT_W(CNT_W)) u_chk (
      .n5     (n5_q),
      .n8     (n8_q),
      .tol_sel(tol_sel),
      .pass   (pass)
   );

   assign mark_nx = mark_q + MARK_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mark_q <= '0;
         n5_q   <= '0;
         n8_q   <= '0;
         ok_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (rise) begin
                  mark_q <= '0;
                  state  <= ST_SPAN5;
               end
            end
            ST_SPAN5, ST_SPAN8: begin
               if (saturated | timed_out) begin
                  ok_q  <= 1'b0;
                  state <= ST_REPORT;
               end else if (rise) begin
                  mark_q <= mark_nx;
                  if (mark_nx == MARK5) begin
                     n5_q  <= span;
                     state <= ST_SPAN8;
                  end else if (mark_nx == MARK8) begin
                     n8_q  <= span;
                     state <= ST_CHECK;
                  end
               end
            end
            ST_CHECK: begin
               ok_q  <= pass;
               state <= ST_REPORT;
            end
            ST_REPORT: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign result_valid = (state == ST_REPORT) &  ok_q;
   assign reject       = (state == ST_REPORT) & ~ok_q;
   assign result_cnt   = n8_q;
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
   parameter int CNT_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                result_valid,
   input logic                reject,
   input logic [CNT_W-1:0]    result_cnt,
   input bpt_pkg::bpt_state_e state,
   input logic                rise,
   input logic                saturated
);
   import bpt_pkg::*;

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(result_valid && reject));

   p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid || reject) |=> !(result_valid || reject));

   p_cnt_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $stable(result_cnt));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && rise) |=> (state == ST_SPAN5));

   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK) |=> (state == ST_REPORT));

   p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REPORT) |=> (state == ST_IDLE));

   p_sat_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_SPAN5 || state == ST_SPAN8) && saturated) |=> reject);
endmodule

bind burst_period_timer bpt_checker #(.CNT_W(CNT_W)) u_bpt_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .result_valid(result_valid),
   .reject      (reject),
   .result_cnt  (result_cnt),
   .state       (state),
   .rise        (rise),
   .saturated   (saturated)
);

// File: tb/burst_period_timer_bench.sv
module burst_period_timer_bench;
   localparam int CNT_W = 16;
   localparam int TMO_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sig_in = 1'b0;
   logic [1:0]       tol_sel = 2'd0;
   logic [TMO_W-1:0] timeout_lim = 16'd200;
   logic             result_valid;
   logic [CNT_W-1:0] result_cnt;
   logic             reject;

   always #5 clk = ~clk;

   burst_period_timer #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_burst_period_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .sig_in      (sig_in),
      .tol_sel     (tol_sel),
      .timeout_lim (timeout_lim),
      .result_valid(result_valid),
      .result_cnt  (result_cnt),
      .reject      (reject)
   );

   typedef struct {
      bit    ok;
      int    cnt;
      string req;
   } exp_t;

   exp_t expq[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   bit   prev_hit = 1'b0;

   task automatic check(input bit cond, input string req, input string what,
                        input int act, input int expv);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Agreement rule from R4, computed independently
   function automatic bit agree(input int n5, input int n8, input int sel);
      int a, b, d;
      a = 8 * n5;
      b = 5 * n8;
      d = (a > b) ? a - b : b - a;
      return d <= (b >> (6 - sel));
   endfunction

   // Drive rising edges spaced by the listed intervals, then one final edge.
   task automatic drive_edges(input int iv[$]);
      @(negedge clk);
      foreach (iv[i]) begin
         sig_in = 1'b1;
         repeat (iv[i] / 2) @(negedge clk);
         sig_in = 1'b0;
         repeat (iv[i] - iv[i] / 2) @(negedge clk);
      end
      sig_in = 1'b1;
      repeat (2) @(negedge clk);
      sig_in = 1'b0;
   endtask

   // Push the expected result of a burst built from eight intervals.
   task automatic expect_burst(input int iv[$], input int sel, input string req);
      int   n5 = 0;
      int   n8 = 0;
      exp_t e;
      for (int i = 0; i < 8; i++) begin
         if (i < 5) n5 += iv[i];
         n8 += iv[i];
      end
      e.ok  = agree(n5, n8, sel);
      e.cnt = n8;
      e.req = req;
      expq.push_back(e);
   endtask

   task automatic expect_reject(input string req);
      exp_t e;
      e.ok  = 1'b0;
      e.cnt = 0;
      e.req = req;
      expq.push_back(e);
   endtask

   task automatic drain();
      while (expq.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard whenever a report appears (R8 checks too)
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hit)
            check(!(result_valid || reject), "R8", "pulse longer than one clock",
                  int'(result_valid || reject), 0);
         if (result_valid || reject) begin
            check(!(result_valid && reject), "R8", "valid and reject together", 1, 0);
            if (expq.size() == 0) begin
               check(1'b0, "R9", "unexpected report", int'(result_valid), 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check(result_valid == e.ok, e.req, "accept flag",
                     int'(result_valid), int'(e.ok));
               if (e.ok)
                  check(int'(result_cnt) == e.cnt, e.req, "result_cnt",
                        int'(result_cnt), e.cnt);
            end
         end
         prev_hit = result_valid || reject;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual %0d pending expected 0", expq.size());
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int iv[$];

      repeat (4) @(negedge clk);
      check(result_valid == 1'b0, "R1", "result_valid in reset", int'(result_valid), 0);
      check(reject == 1'b0, "R1", "reject in reset", int'(reject), 0);
      check(result_cnt == '0, "R1", "result_cnt in reset", int'(result_cnt), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!(result_valid || reject), "R1", "idle after reset",
            int'(result_valid || reject), 0);

      // R2, R3: steady 20-clock period, start edge not counted -> 160
      iv = {20, 20, 20, 20, 20, 20, 20, 20};
      tol_sel = 2'd0;
      expect_burst(iv, 0, "R3");
      drive_edges(iv);
      drain();

      // R3, R2: steady 37-clock period, widest tolerance -> 296
      iv = {37, 37, 37, 37, 37, 37, 37, 37};
      tol_sel = 2'd3;
      expect_burst(iv, 3, "R2");
      drive_edges(iv);
      drain();

      // R4/R5: N5=100 N8=163 -> diff 15; 1/64 limit 12 rejects
      iv = {20, 20, 20, 20, 20, 21, 21, 21};
      tol_sel = 2'd0;
      check(!agree(100, 163, 0), "R5", "bench rule at 1/64", 1, 0);
      expect_burst(iv, 0, "R5");
      drive_edges(iv);
      drain();

      // R4: same burst, 1/32 limit 25 accepts -> 163
      tol_sel = 2'd1;
      check(agree(100, 163, 1), "R4", "bench rule at 1/32", 0, 1);
      expect_burst(iv, 1, "R4");
      drive_edges(iv);
      drain();

      // R4: 1/16 setting, accept
      tol_sel = 2'd2;
      expect_burst(iv, 2, "R4");
      drive_edges(iv);
      drain();

      // R5: N5=100 N8=190 -> diff 150 beyond 1/8 limit 118
      iv = {20, 20, 20, 20, 20, 30, 30, 30};
      tol_sel = 2'd3;
      expect_burst(iv, 3, "R5");
      drive_edges(iv);
      drain();

      // R9: continuous train of 18 edges -> two back-to-back results of 200
      iv = {};
      for (int i = 0; i < 17; i++) iv.push_back(25);
      tol_sel = 2'd0;
      begin
         int one[$];
         one = {25, 25, 25, 25, 25, 25, 25, 25};
         expect_burst(one, 0, "R9");
         expect_burst(one, 0, "R9");
      end
      drive_edges(iv);
      drain();

      // R6: three edges then silence -> timeout reject
      timeout_lim = 16'd200;
      iv = {20, 20};
      expect_reject("R6");
      drive_edges(iv);
      drain();

      // R7: 10000-clock spans, 7 edges, counter saturates before 8th cycle
      timeout_lim = 16'd20000;
      iv = {10000, 10000, 10000, 10000, 10000, 10000};
      expect_reject("R7");
      drive_edges(iv);
      drain();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule